// File: doc/BRIEF.md
# Flash Page-Write Programming Controller

This block sits between a CPU register bus and a program-memory array and turns a series of single-byte table writes into one page-sized program operation. Each table write copies the one-byte data latch into one of eight holding slots. The low three bits of the table pointer pick the slot, and the pointer can step forward after each write. The array itself does not change during these short writes.

A long write commits the whole holding buffer. It starts only after a fixed unlock key sequence on the control port, and only when the control bits select program memory with writing enabled. While the programming timer runs, the block holds the CPU in a stall. When the timer expires, it writes all eight bytes to the memory port in one wide transfer, pulses a done flag for one cycle and empties the holding buffer.

The bus map is as follows:

| Bus address | Register |
|---|---|
| 0 | Data latch |
| 1 | Control 1 |
| 2 | Control 2 (key port) |

Control 1 holds these bits:

| Bit | Function |
|---|---|
| 0 | Start |
| 1 | Write enable |
| 2 | Config select |
| 3 | Memory select |

Top module: `flash_page_writer`

## Requirements
- R1: After reset these outputs are low: stall, memory write enable and done. The table pointer output is zero.
- R2: A table write stores the data latch (bus address 0) into holding slot `tbl_ptr_o[2:0]`. A later write to the same slot replaces the earlier value. Table writes never assert the memory write enable.
- R3: A table write with `tbl_inc` high adds one to the table pointer, wrapping from all-ones to zero. With `tbl_inc` low the pointer is unchanged.
- R4: A commit starts only when three bus writes come on consecutive bus accesses, in this order: 55h to address 2, AAh to address 2, then a write to address 1 with bit 0 set. Any other bus write, table write or pointer load in between, or a wrong key, cancels the sequence, and that start write is ignored.
- R5: The start write also needs these values in the same written byte: bit 1 (write enable) = 1, bit 3 (memory select) = 1, bit 2 (config select) = 0. Otherwise nothing starts.
- R6: Once a commit starts, `stall_o` rises in the cycle after the start write and stays high for exactly PROG_CYCLES clock cycles.
- R7: In the cycle after the stall ends, `mem_we_o` and `done_o` are high for one cycle. `mem_addr_o` equals `tbl_ptr_o[ADDR_W-1:3]` as it was at the start write. Bits [8k+7:8k] of `mem_wdata_o` hold slot k.
- R8: The holding buffer is all zero after each commit and after reset, so a commit with no new table writes stores all-zero data.
- R9: While `stall_o` is high, table writes, pointer loads and bus writes have no effect on the table pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 2 | Register select: 0 data latch, 1 control 1, 2 control 2 |
| bus_wdata | input | 8 | Register write data |
| tbl_wr | input | 1 | Table write strobe |
| tbl_inc | input | 1 | Step pointer after this table write |
| ptr_load | input | 1 | Load table pointer |
| ptr_value | input | ADDR_W | Value for pointer load |
| tbl_ptr_o | output | ADDR_W | Current table pointer |
| stall_o | output | 1 | CPU stall, high while programming |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W-3 | Page address of array write |
| mem_wdata_o | output | 64 | Eight buffered bytes |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a commit whose destination page comes from a pointer that is no longer where the table writes left it. Auto-increment carries the pointer into the next page after the eighth byte. The bench therefore reloads the pointer to the start of the run before the key sequence, and it includes runs that start mid-page and runs that wrap across the top of the address space. Key sequences broken by an unrelated access, or sent in the wrong order, must be shown to leave both the array port and the stall silent for the full timer window.

// File: rtl/fpw_pkg.sv
// Shared constants and types for the page-write controller.
// Assumes an 8-bit register bus with the address map below.
package fpw_pkg;
    localparam logic [1:0] REG_LATCH = 2'd0;
    localparam logic [1:0] REG_CTRL1 = 2'd1;
    localparam logic [1:0] REG_CTRL2 = 2'd2;

    localparam int CB_START = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_CFG   = 2;
    localparam int CB_MEM   = 3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_KEY1 = 2'd1,
        UL_KEY2 = 2'd2
    } unlock_t;
endpackage

// File: rtl/fpw_hold_buf.sv
// Holding buffer: one byte-wide slot per page byte. Assumes that wr_en and
// clear never overlap in a useful way; clear wins if they do.
module fpw_hold_buf #(
    parameter int PAGE_BYTES = 8,
    localparam int SEL_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        sel,
    input  logic [7:0]              wr_data,
    input  logic                    clear,
    output logic [PAGE_BYTES*8-1:0] data_o
);
    for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
        logic [7:0] slot_q;
        // Load or clear this slot
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot_q <= '0;
            else if (clear)                          slot_q <= '0;
            else if (wr_en && sel == SEL_W'(k))      slot_q <= wr_data;
        end
        assign data_o[k*8 +: 8] = slot_q;
    end

    // R8
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> data_o == '0);
endmodule

// File: rtl/fpw_unlock.sv
// Unlock checker: tracks the two key writes and flags a valid start write.
// Assumes every bus write, table write and pointer load is one access.
module fpw_unlock
    import fpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       block,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       other_access,
    output logic       armed_o,
    output logic       go_o
);
    unlock_t st_q;

    // Advance or reset the key sequence
    always_ff @(posedge clk) begin
        if (!rst_n || block || other_access) st_q <= UL_IDLE;
        else if (bus_we) begin
            if (bus_addr == REG_CTRL2 && bus_wdata == KEY_FIRST)
                st_q <= UL_KEY1;
            else if (st_q == UL_KEY1 && bus_addr == REG_CTRL2 && bus_wdata == KEY_SECOND)
                st_q <= UL_KEY2;
            else
                st_q <= UL_IDLE;
        end
    end

    assign armed_o = (st_q == UL_KEY2);

    // Decode a legal start write
    always_comb begin
        go_o = !block && !other_access && bus_we && armed_o &&
               bus_addr == REG_CTRL1 && bus_wdata[CB_START] &&
               bus_wdata[CB_WEN] && bus_wdata[CB_MEM] && !bus_wdata[CB_CFG];
    end
endmodule

// File: rtl/fpw_prog_timer.sv
// Programming timer: busy for PROG_CYCLES cycles after start, then flags
// expiry in its last busy cycle. Start is ignored while busy.
module fpw_prog_timer #(
    parameter int PROG_CYCLES = 400000,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the program window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_o) begin
            if (start) begin
                busy_o <= 1'b1;
                cnt_q  <= CNT_W'(PROG_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_o <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = busy_o && (cnt_q == '0);

    // R6
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> cnt_q < CNT_W'(PROG_CYCLES));
endmodule

// File: rtl/flash_page_writer.sv
// Page-write controller top: data latch, table pointer, holding buffer,
// unlock checker and timed commit to a wide memory write port.
// Assumes a page of PAGE_BYTES bytes aligned on its own size.
module flash_page_writer
    import fpw_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 400000,
    localparam int SEL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [1:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    input  logic                    tbl_wr,
    input  logic                    tbl_inc,
    input  logic                    ptr_load,
    input  logic [ADDR_W-1:0]       ptr_value,
    output logic [ADDR_W-1:0]       tbl_ptr_o,
    output logic                    stall_o,
    output logic                    mem_we_o,
    output logic [PAGE_W-1:0]       mem_addr_o,
    output logic [PAGE_BYTES*8-1:0] mem_wdata_o,
    output logic                    done_o
);
    logic [7:0]              latch_q;
    logic [PAGE_W-1:0]       page_q;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic                    busy, expire, go, armed;

    // Byte data latch written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else if (!busy && bus_we && bus_addr == REG_LATCH) latch_q <= bus_wdata;
    end

    // Table pointer load and post-increment
    always_ff @(posedge clk) begin
        if (!rst_n)                      tbl_ptr_o <= '0;
        else if (!busy) begin
            if (ptr_load)                tbl_ptr_o <= ptr_value;
            else if (tbl_wr && tbl_inc)  tbl_ptr_o <= tbl_ptr_o + 1'b1;
        end
    end

    // Capture destination page on a legal start
    always_ff @(posedge clk) begin
        if (!rst_n)  page_q <= '0;
        else if (go) page_q <= tbl_ptr_o[ADDR_W-1:SEL_W];
    end

    // Issue the wide array write and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_o    <= 1'b0;
            done_o      <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
        end else begin
            mem_we_o <= expire;
            done_o   <= expire;
            if (expire) begin
                mem_addr_o  <= page_q;
                mem_wdata_o <= buf_data;
            end
        end
    end

    assign stall_o = busy;

    fpw_hold_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr && !busy), .sel(tbl_ptr_o[SEL_W-1:0]),
        .wr_data(latch_q), .clear(expire), .data_o(buf_data)
    );

    fpw_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .block(busy),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .other_access(tbl_wr || ptr_load),
        .armed_o(armed), .go_o(go)
    );

    fpw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go),
        .busy_o(busy), .expire_o(expire)
    );

    // R4
    unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(armed) && $past(bus_we));
    // R7
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !stall_o && $past(stall_o));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(tbl_ptr_o));
endmodule

// File: tb/sim_flash_page_writer.sv
module sim_flash_page_writer;
    localparam int ADDR_W = 12;
    localparam int PAGE_BYTES = 8;
    localparam int PROG = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic tbl_wr = 1'b0, tbl_inc = 1'b0, ptr_load = 1'b0;
    logic [ADDR_W-1:0] ptr_value = '0;
    logic [ADDR_W-1:0] tbl_ptr_o;
    logic stall_o, mem_we_o, done_o;
    logic [ADDR_W-4:0] mem_addr_o;
    logic [63:0] mem_wdata_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_page_writer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tbl_wr(tbl_wr), .tbl_inc(tbl_inc),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .tbl_ptr_o(tbl_ptr_o),
        .stall_o(stall_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [11:0] ptr;
        logic [7:0]  base;
        logic [7:0]  k1;
        logic [7:0]  k2;
        logic [7:0]  ctrl;
        logic        ok;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{12'h000, 8'h10, 8'h55, 8'hAA, 8'h0B, 1'b1},
        '{12'h005, 8'h20, 8'h55, 8'hAA, 8'h0B, 1'b1},
        '{12'h7A8, 8'h30, 8'h55, 8'hAA, 8'h0B, 1'b1},
        '{12'hFFC, 8'h40, 8'h55, 8'hAA, 8'h0B, 1'b1},
        '{12'h100, 8'h50, 8'h54, 8'hAA, 8'h0B, 1'b0},
        '{12'h100, 8'h60, 8'hAA, 8'h55, 8'h0B, 1'b0},
        '{12'h100, 8'h70, 8'h55, 8'hAA, 8'h09, 1'b0},
        '{12'h100, 8'h80, 8'h55, 8'hAA, 8'h0F, 1'b0},
        '{12'h100, 8'h90, 8'h55, 8'hAA, 8'h03, 1'b0},
        '{12'h100, 8'hA0, 8'h55, 8'hAA, 8'h0A, 1'b0},
        '{12'h238, 8'hB0, 8'h55, 8'hAA, 8'h0B, 1'b1}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ptr_ld(input logic [11:0] v);
        ptr_load = 1'b1; ptr_value = v;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic tbl_write(input logic [7:0] d, input logic inc);
        bus_wr(2'd0, d);
        tbl_wr = 1'b1; tbl_inc = inc;
        @(negedge clk);
        tbl_wr = 1'b0; tbl_inc = 1'b0;
    endtask

    task automatic try_commit(input logic [7:0] k1, input logic [7:0] k2, input logic [7:0] c);
        bus_wr(2'd2, k1);
        bus_wr(2'd2, k2);
        bus_wr(2'd1, c);
    endtask

    // Called at the negedge after the start write
    task automatic observe(input logic ok, input logic [8:0] ea, input logic [63:0] ew, input string tag);
        int n = 0;
        bit seen = 0;
        if (ok) begin
            while (stall_o && n < 1000) begin n++; @(negedge clk); end
            chk(n == PROG, {tag, " R6 stall length"}, 64'(n), 64'(PROG));
            chk(mem_we_o && done_o, {tag, " R7 we/done"}, {mem_we_o, done_o}, 2'b11);
            chk(mem_addr_o == ea, {tag, " R7 page"}, 64'(mem_addr_o), 64'(ea));
            chk(mem_wdata_o == ew, {tag, " R7 data"}, mem_wdata_o, ew);
            @(negedge clk);
            chk(!mem_we_o && !done_o, {tag, " R7 one-cycle"}, {mem_we_o, done_o}, 2'b00);
        end else begin
            for (int i = 0; i < PROG + 4; i++) begin
                if (stall_o || mem_we_o) seen = 1;
                @(negedge clk);
            end
            chk(!seen, {tag, " R4/R5 no commit"}, 64'(seen), 64'd0);
        end
    endtask

    function automatic logic [63:0] expect_word(input logic [11:0] st, input logic [7:0] b);
        logic [63:0] w = '0;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] s = st[2:0] + 3'(i);
            w[s*8 +: 8] = b + 8'(i);
        end
        return w;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!stall_o && !mem_we_o && !done_o, "R1 outputs low", {stall_o, mem_we_o, done_o}, 0);
        chk(tbl_ptr_o == 0, "R1 pointer zero", 64'(tbl_ptr_o), 0);

        // Vector table: R2, R4, R5, R6, R7
        for (int v = 0; v < 11; v++) begin
            ptr_ld(VECS[v].ptr);
            for (int i = 0; i < 8; i++) tbl_write(VECS[v].base + 8'(i), 1'b1);
            chk(!mem_we_o, "R2 no array write on table write", 64'(mem_we_o), 0);
            ptr_ld(VECS[v].ptr);
            try_commit(VECS[v].k1, VECS[v].k2, VECS[v].ctrl);
            observe(VECS[v].ok, VECS[v].ptr[11:3], expect_word(VECS[v].ptr, VECS[v].base),
                    $sformatf("vec%0d", v));
        end

        // R8 buffer empty after commit
        ptr_ld(12'h040);
        try_commit(8'h55, 8'hAA, 8'h0B);
        observe(1'b1, 9'h008, 64'd0, "R8 after-commit");

        // R2 overwrite same slot with no increment; R3 pointer held
        ptr_ld(12'h013);
        tbl_write(8'h11, 1'b0);
        tbl_write(8'h22, 1'b0);
        chk(tbl_ptr_o == 12'h013, "R3 no increment", 64'(tbl_ptr_o), 64'h013);
        try_commit(8'h55, 8'hAA, 8'h0B);
        observe(1'b1, 9'h002, 64'h22 << 24, "R2 overwrite");

        // R3 wrap
        ptr_ld(12'hFFF);
        tbl_write(8'h01, 1'b1);
        chk(tbl_ptr_o == 12'h000, "R3 wrap", 64'(tbl_ptr_o), 0);

        // R4 interleaved access breaks the sequence
        ptr_ld(12'h000);
        bus_wr(2'd2, 8'h55);
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd1, 8'h0B);
        observe(1'b0, 9'h0, 64'd0, "R4 interleave");

        // R9 pointer frozen during stall
        ptr_ld(12'h300);
        try_commit(8'h55, 8'hAA, 8'h0B);
        tbl_wr = 1'b1; tbl_inc = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0; tbl_inc = 1'b0;
        ptr_ld(12'h555);
        chk(stall_o && tbl_ptr_o == 12'h300, "R9 pointer held in stall", 64'(tbl_ptr_o), 64'h300);
        while (stall_o) @(negedge clk);
        @(negedge clk);
        chk(tbl_ptr_o == 12'h300, "R9 pointer after stall", 64'(tbl_ptr_o), 64'h300);

        // R8 reset clears buffer; R1 pointer cleared
        ptr_ld(12'h008);
        for (int i = 0; i < 4; i++) tbl_write(8'hC0 + 8'(i), 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tbl_ptr_o == 0, "R1 pointer after reset", 64'(tbl_ptr_o), 0);
        try_commit(8'h55, 8'hAA, 8'h0B);
        observe(1'b1, 9'h000, 64'd0, "R8 reset-clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule